// File: doc/BRIEF.md
# Write-Drain Command Scheduler with On-Chip Read Staging

This block sits in a memory controller and turns a stream of tagged read and write requests into a stream of device commands. Reads are served as they arrive. Writes are held back in a queue. Once enough writes have collected, the scheduler switches into a drain and sends them out as one batch. It leaves the drain when the queue has shrunk to a lower mark.

During a drain, ordinary reads would stall behind the writes. Instead, a waiting read whose bank has no queued write can be sent as a stage command. The device then fetches the data into one of a small ring of on-chip holding slots, leaving the data bus free for the writes.

After the last write of the batch, the bus has to settle: first the write data transfer completes, then the direction change takes place. Once that gap has passed, the scheduler empties the holding slots with unload commands, oldest first. After that it returns to ordinary reads.

Top module: `wds_sched`

## Requirements
- R1: After reset, `req_ready` is high. A write is accepted only while the write queue (8 entries) has room, and a read only while the read queue (8 entries) has room. Outside a drain, no write command (cmd_op 1) appears unless write-queue occupancy has reached the high mark of 6.
- R2: Within a drain, write commands leave in the order the writes were accepted, each carrying its own bank and tag.
- R3: A command that names a bank (write 1, read 2, stage 3) appears only if that bank's `bank_busy` bit was low at the clock edge that launched it.
- R4: A drain ends on the write that leaves occupancy at or below the low mark of 2, counting a write accepted on the same edge. No further write is issued until occupancy again reaches 6.
- R5: No ordinary read (cmd_op 2) is issued from the start of a drain until every holding slot has been unloaded.
- R6: A read (2) or unload (4) command appears no sooner than WR_LAT+TURN_CYC = 10 cycles after the last write command. When an unload is waiting, the first one appears exactly 10 cycles after it.
- R7: A stage command (3) is issued only during a drain, and only for a read whose bank has no write in the write queue. A read to a bank with a queued write waits for an ordinary read.
- R8: At most 16 stage commands are outstanding. `cmd_slot` on a stage command takes the ring slots 0,1,2,… in turn, wrapping after 15.
- R9: Unload commands (4) come after the drain ends, in the same order as the stage commands. Each carries the slot and tag of its stage command.
- R10: Every accepted read is served exactly once, either as a read or as a stage/unload pair. Among the reads eligible in a cycle, the oldest is chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_bank | input | 3 | Target bank of the request |
| req_tag | input | 8 | Request identifier returned on the command |
| req_ready | output | 1 | Queue selected by req_write can take the request |
| bank_busy | input | 8 | Per-bank busy flags; a busy bank takes no command |
| cmd_valid | output | 1 | Command present this cycle |
| cmd_op | output | 3 | 1 write, 2 read, 3 stage, 4 unload |
| cmd_bank | output | 3 | Bank of a write, read or stage command |
| cmd_slot | output | 4 | Holding slot of a stage or unload command |
| cmd_tag | output | 8 | Tag of the request the command serves |

## Verification
A corrupted queue pointer or per-bank write counter shows at the ports on the next command. The wrong tag or bank leaves, or a stage command goes to a bank that still holds a queued write. A wrong phase or turnaround count shows as a read or unload landing inside the ten-cycle window after a write, or as an ordinary read while slots are still full. A ring pointer that slips is seen on the first unload whose slot or tag differs from the stage command it should mirror.

// File: rtl/wds_pkg.sv
package wds_pkg;

    localparam int NUM_BANKS = 8;
    localparam int BANK_W    = $clog2(NUM_BANKS);
    localparam int TAG_W     = 8;

    typedef logic [BANK_W-1:0] bank_t;
    typedef logic [TAG_W-1:0]  tag_t;

    typedef struct packed {
        bank_t bank;
        tag_t  tag;
    } req_t;

    typedef enum logic [2:0] {
        OP_NONE      = 3'd0,
        OP_WRITE     = 3'd1,
        OP_READ      = 3'd2,
        OP_STAGE     = 3'd3,
        OP_DRAIN_OUT = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        PH_NORMAL,
        PH_DRAIN,
        PH_TURN,
        PH_FLUSH
    } phase_e;

    function automatic logic bank_hit(input bank_t a, input int b);
        return a == bank_t'(b);
    endfunction

endpackage

// File: rtl/wds_wr_queue.sv
module wds_wr_queue
    import wds_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 push,
    input  req_t                 push_ent,
    input  logic                 pop,
    output req_t                 head,
    output logic [CNT_W-1:0]     count,
    output logic                 full,
    output logic [NUM_BANKS-1:0] bank_pend
);

    req_t             mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;

    assign full = count == CNT_W'(DEPTH);
    assign head = mem[rp];

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= push_ent;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (pop)  rp <= (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [CNT_W-1:0] n;
        logic             inc, dec;
        assign inc = push && bank_hit(push_ent.bank, b);
        assign dec = pop && bank_hit(head.bank, b);
        always_ff @(posedge clk) begin
            if (rst) n <= '0;
            else     n <= n + CNT_W'(inc) - CNT_W'(dec);
        end
        assign bank_pend[b] = n != '0;

        AST_BANK_CNT_LIVE: assert property (@(posedge clk) disable iff (rst)
            dec |-> n != '0); // R7
    end

    AST_WQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        push |-> !full); // R1
    AST_WQ_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        pop |-> count != '0); // R2

endmodule

// File: rtl/wds_rd_queue.sv
module wds_rd_queue
    import wds_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 push,
    input  req_t                 push_ent,
    input  logic [NUM_BANKS-1:0] bank_ok,
    input  logic                 pop,
    output logic                 pick_valid,
    output req_t                 pick_ent,
    output logic                 full
);

    req_t             ent   [DEPTH];
    req_t             ent_n [DEPTH];
    logic [CNT_W-1:0] count, cnt_after;
    logic [IDX_W-1:0] pick_idx;

    assign full = count == CNT_W'(DEPTH);

    // lowest index is oldest; scan from the top so the oldest eligible wins
    always_comb begin
        pick_valid = 1'b0;
        pick_idx   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (CNT_W'(i) < count && bank_ok[ent[i].bank]) begin
                pick_valid = 1'b1;
                pick_idx   = IDX_W'(i);
            end
        end
    end

    assign pick_ent  = ent[pick_idx];
    assign cnt_after = count - CNT_W'(pop);

    always_comb begin
        for (int i = 0; i < DEPTH; i++) ent_n[i] = ent[i];
        if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (IDX_W'(i) >= pick_idx) ent_n[i] = ent[i + 1];
            end
        end
        if (push) ent_n[cnt_after[IDX_W-1:0]] = push_ent;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) ent[i] <= ent_n[i];
    end

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count + CNT_W'(push) - CNT_W'(pop);
    end

    AST_RQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        push |-> !full); // R1
    AST_RQ_POP_HAS_PICK: assert property (@(posedge clk) disable iff (rst)
        pop |-> pick_valid && count != '0); // R10

endmodule

// File: rtl/wds_stage_pool.sv
module wds_stage_pool
    import wds_pkg::*;
#(
    parameter  int SLOTS  = 16,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int CNT_W  = $clog2(SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc,
    input  tag_t              alloc_tag,
    output logic [SLOT_W-1:0] alloc_slot,
    input  logic              unload,
    output logic [SLOT_W-1:0] out_slot,
    output tag_t              out_tag,
    output logic              has_free,
    output logic              empty
);

    tag_t              tags [SLOTS];
    logic [SLOT_W-1:0] wp, rp;
    logic [CNT_W-1:0]  used;

    assign alloc_slot = wp;
    assign out_slot   = rp;
    assign out_tag    = tags[rp];
    assign has_free   = used != CNT_W'(SLOTS);
    assign empty      = used == '0;

    always_ff @(posedge clk) begin
        if (alloc) tags[wp] <= alloc_tag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp   <= '0;
            rp   <= '0;
            used <= '0;
        end else begin
            if (alloc)  wp <= (wp == SLOT_W'(SLOTS - 1)) ? '0 : wp + 1'b1;
            if (unload) rp <= (rp == SLOT_W'(SLOTS - 1)) ? '0 : rp + 1'b1;
            used <= used + CNT_W'(alloc) - CNT_W'(unload);
        end
    end

    AST_POOL_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        alloc |-> has_free); // R8
    AST_POOL_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        unload |-> !empty); // R9

endmodule

// File: rtl/wds_sched.sv
module wds_sched
    import wds_pkg::*;
#(
    parameter  int WQ_DEPTH = 8,
    parameter  int RQ_DEPTH = 8,
    parameter  int HI_MARK  = 6,
    parameter  int LO_MARK  = 2,
    parameter  int SLOTS    = 16,
    parameter  int WR_LAT   = 4,
    parameter  int TURN_CYC = 6,
    localparam int SLOT_W   = $clog2(SLOTS),
    localparam int GAP      = WR_LAT + TURN_CYC,
    localparam int GAP_W    = $clog2(GAP + 1),
    localparam int WQ_CW    = $clog2(WQ_DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [BANK_W-1:0]    req_bank,
    input  logic [TAG_W-1:0]     req_tag,
    output logic                 req_ready,
    input  logic [NUM_BANKS-1:0] bank_busy,
    output logic                 cmd_valid,
    output logic [2:0]           cmd_op,
    output logic [BANK_W-1:0]    cmd_bank,
    output logic [SLOT_W-1:0]    cmd_slot,
    output logic [TAG_W-1:0]     cmd_tag
);

    phase_e               phase, phase_n;
    logic [GAP_W-1:0]     gap_cnt, gap_cnt_n;

    req_t                 in_ent, wq_head, rd_pick;
    logic [WQ_CW-1:0]     wq_count;
    logic                 wq_full, rq_full;
    logic [NUM_BANKS-1:0] wq_pend, bank_ok;
    logic                 rd_pick_valid;
    logic [SLOT_W-1:0]    alloc_slot, out_slot;
    tag_t                 out_tag;
    logic                 pool_free, pool_empty;

    logic acc_w, acc_r, write_go, stage_go, read_go, out_go, drain_end, above_hi;

    op_e               op_q, op_n;
    logic [BANK_W-1:0] bank_n;
    logic [SLOT_W-1:0] slot_n;
    tag_t              tag_n;
    logic [NUM_BANKS-1:0] busy_d;

    assign in_ent    = '{bank: req_bank, tag: req_tag};
    assign acc_w     = req_valid && req_write && !wq_full;
    assign acc_r     = req_valid && !req_write && !rq_full;
    assign req_ready = req_write ? !wq_full : !rq_full;
    assign above_hi  = int'(wq_count) >= HI_MARK;

    always_comb begin
        unique case (phase)
            PH_NORMAL: bank_ok = ~bank_busy;
            PH_DRAIN:  bank_ok = ~bank_busy & ~wq_pend & {NUM_BANKS{pool_free}};
            default:   bank_ok = '0;
        endcase
    end

    assign write_go  = phase == PH_DRAIN && wq_count != '0 && !bank_busy[wq_head.bank];
    assign stage_go  = phase == PH_DRAIN && !write_go && rd_pick_valid;
    assign read_go   = phase == PH_NORMAL && !above_hi && rd_pick_valid;
    assign out_go    = phase == PH_FLUSH && !pool_empty;
    assign drain_end = write_go && (int'(wq_count) + int'(acc_w) <= LO_MARK + 1);

    wds_wr_queue #(.DEPTH(WQ_DEPTH)) u_wq (
        .clk(clk), .rst(rst),
        .push(acc_w), .push_ent(in_ent), .pop(write_go),
        .head(wq_head), .count(wq_count), .full(wq_full), .bank_pend(wq_pend)
    );

    wds_rd_queue #(.DEPTH(RQ_DEPTH)) u_rq (
        .clk(clk), .rst(rst),
        .push(acc_r), .push_ent(in_ent), .bank_ok(bank_ok),
        .pop(stage_go || read_go),
        .pick_valid(rd_pick_valid), .pick_ent(rd_pick), .full(rq_full)
    );

    wds_stage_pool #(.SLOTS(SLOTS)) u_pool (
        .clk(clk), .rst(rst),
        .alloc(stage_go), .alloc_tag(rd_pick.tag), .alloc_slot(alloc_slot),
        .unload(out_go), .out_slot(out_slot), .out_tag(out_tag),
        .has_free(pool_free), .empty(pool_empty)
    );

    // phase sequencing; the turn counter is loaded so the first read-side
    // command lands GAP cycles after the final write command
    always_comb begin
        phase_n   = phase;
        gap_cnt_n = gap_cnt;
        unique case (phase)
            PH_NORMAL: if (above_hi) phase_n = PH_DRAIN;
            PH_DRAIN: begin
                if (drain_end) begin
                    phase_n   = PH_TURN;
                    gap_cnt_n = GAP_W'(GAP - 2);
                end
            end
            PH_TURN: begin
                if (gap_cnt == '0) phase_n = pool_empty ? PH_NORMAL : PH_FLUSH;
                else               gap_cnt_n = gap_cnt - 1'b1;
            end
            PH_FLUSH: if (pool_empty) phase_n = PH_NORMAL;
            default:  phase_n = PH_NORMAL;
        endcase
    end

    always_comb begin
        op_n   = OP_NONE;
        bank_n = '0;
        slot_n = '0;
        tag_n  = '0;
        if (write_go) begin
            op_n   = OP_WRITE;
            bank_n = wq_head.bank;
            tag_n  = wq_head.tag;
        end else if (stage_go) begin
            op_n   = OP_STAGE;
            bank_n = rd_pick.bank;
            tag_n  = rd_pick.tag;
            slot_n = alloc_slot;
        end else if (read_go) begin
            op_n   = OP_READ;
            bank_n = rd_pick.bank;
            tag_n  = rd_pick.tag;
        end else if (out_go) begin
            op_n   = OP_DRAIN_OUT;
            slot_n = out_slot;
            tag_n  = out_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_NORMAL;
            gap_cnt   <= '0;
            op_q      <= OP_NONE;
            cmd_valid <= 1'b0;
            cmd_bank  <= '0;
            cmd_slot  <= '0;
            cmd_tag   <= '0;
            busy_d    <= '0;
        end else begin
            phase     <= phase_n;
            gap_cnt   <= gap_cnt_n;
            op_q      <= op_n;
            cmd_valid <= op_n != OP_NONE;
            cmd_bank  <= bank_n;
            cmd_slot  <= slot_n;
            cmd_tag   <= tag_n;
            busy_d    <= bank_busy;
        end
    end

    assign cmd_op = op_q;

    AST_BUSY_BANK_SKIPPED: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && (op_q == OP_WRITE || op_q == OP_READ || op_q == OP_STAGE)
        |-> !busy_d[cmd_bank]); // R3
    AST_TURN_GAP_KEPT: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && op_q == OP_WRITE
        |=> !(cmd_valid && (op_q == OP_READ || op_q == OP_DRAIN_OUT))); // R6
    AST_READ_AFTER_FLUSH: assert property (@(posedge clk) disable iff (rst)
        read_go |-> pool_empty); // R5
    AST_STAGE_CLEAR_BANK: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && op_q == OP_STAGE |-> $past(phase) == PH_DRAIN); // R7

endmodule

// File: tb/tb_wds_sched.sv
module tb_wds_sched;
    import wds_pkg::*;

    localparam int HI = 6;
    localparam int LO = 2;
    localparam int NSL = 16;
    localparam int G  = 10;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic                 rst;
    logic                 req_valid, req_write, req_ready;
    logic [BANK_W-1:0]    req_bank;
    logic [TAG_W-1:0]     req_tag;
    logic [NUM_BANKS-1:0] bank_busy;
    logic                 cmd_valid;
    logic [2:0]           cmd_op;
    logic [BANK_W-1:0]    cmd_bank;
    logic [3:0]           cmd_slot;
    logic [TAG_W-1:0]     cmd_tag;

    wds_sched dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_bank(req_bank), .req_tag(req_tag), .req_ready(req_ready),
        .bank_busy(bank_busy), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_slot(cmd_slot), .cmd_tag(cmd_tag)
    );

    typedef struct { int bank; int tag; } ent_t;

    ent_t rdq[$];
    ent_t wrq[$];
    ent_t stq[$];      // bank field holds the slot
    int   wcnt[NUM_BANKS];
    int   checks = 0, fails = 0, cyc = 0;
    int   last_wr = -1000, next_slot = 0, gap_seen = -1;
    int   n_stage = 0, n_read = 0;
    bit   in_drain = 0, prev_out = 0, last_acc = 0;
    logic [7:0] tag_ctr = 8'd0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int find_rd(input int tag);
        for (int i = 0; i < rdq.size(); i++) if (rdq[i].tag == tag) return i;
        return -1;
    endfunction

    function automatic int older_eligible(input int idx, input logic [NUM_BANKS-1:0] busy,
                                          input bit need_clear);
        for (int j = 0; j < idx; j++)
            if (!busy[rdq[j].bank] && (!need_clear || wcnt[rdq[j].bank] == 0)) return j;
        return -1;
    endfunction

    task automatic monitor(input logic [NUM_BANKS-1:0] busy, output bit wseen);
        int idx;
        wseen = 0;
        if (!cmd_valid) begin
            prev_out = 0;
            return;
        end
        case (int'(cmd_op))
            1: begin
                chk(wrq.size() > 0 && wrq[0].tag == int'(cmd_tag) && wrq[0].bank == int'(cmd_bank),
                    "R2", int'(cmd_tag), wrq.size() > 0 ? wrq[0].tag : -1);
                chk(!busy[cmd_bank], "R3", 1, 0);
                if (!in_drain) begin
                    chk(wrq.size() >= HI, "R1", wrq.size(), HI);
                    in_drain = 1;
                end
                if (wrq.size() > 0) begin
                    wcnt[wrq[0].bank]--;
                    void'(wrq.pop_front());
                end
                last_wr = cyc;
                wseen = 1;
            end
            2: begin
                idx = find_rd(int'(cmd_tag));
                chk(idx >= 0 && (idx < 0 || rdq[idx].bank == int'(cmd_bank)), "R10", int'(cmd_tag), idx);
                chk(!busy[cmd_bank], "R3", 1, 0);
                chk(!in_drain && stq.size() == 0, "R5", stq.size(), 0);
                chk(cyc - last_wr >= G, "R6", cyc - last_wr, G);
                if (idx >= 0) begin
                    chk(older_eligible(idx, busy, 0) < 0, "R10", idx, older_eligible(idx, busy, 0));
                    rdq.delete(idx);
                end
                n_read++;
            end
            3: begin
                idx = find_rd(int'(cmd_tag));
                chk(idx >= 0 && (idx < 0 || rdq[idx].bank == int'(cmd_bank)), "R10", int'(cmd_tag), idx);
                chk(!busy[cmd_bank], "R3", 1, 0);
                chk(wcnt[cmd_bank] == 0, "R7", wcnt[cmd_bank], 0);
                chk(in_drain || wrq.size() >= HI, "R7", wrq.size(), HI);
                chk(stq.size() < NSL, "R8", stq.size(), NSL - 1);
                chk(int'(cmd_slot) == next_slot, "R8", int'(cmd_slot), next_slot);
                if (idx >= 0) begin
                    chk(older_eligible(idx, busy, 1) < 0, "R10", idx, older_eligible(idx, busy, 1));
                    rdq.delete(idx);
                end
                in_drain = 1;
                stq.push_back('{bank: int'(cmd_slot), tag: int'(cmd_tag)});
                next_slot = (next_slot + 1) % NSL;
                n_stage++;
            end
            4: begin
                chk(stq.size() > 0 && stq[0].bank == int'(cmd_slot) && stq[0].tag == int'(cmd_tag),
                    "R9", int'(cmd_tag), stq.size() > 0 ? stq[0].tag : -1);
                chk(!in_drain, "R9", 1, 0);
                chk(cyc - last_wr >= G, "R6", cyc - last_wr, G);
                if (!prev_out) gap_seen = cyc - last_wr;
                if (stq.size() > 0) void'(stq.pop_front());
            end
            default: chk(0, "R11", int'(cmd_op), 1);
        endcase
        prev_out = int'(cmd_op) == 4;
    endtask

    task automatic step(input bit v, input bit w, input int b, input logic [NUM_BANKS-1:0] busy);
        bit acc, wseen;
        req_valid = v;
        req_write = w;
        req_bank  = BANK_W'(b);
        req_tag   = tag_ctr;
        bank_busy = busy;
        #1;
        acc = v && req_ready;
        last_acc = acc;
        @(negedge clk);
        cyc++;
        monitor(busy, wseen);
        if (acc) begin
            if (w) begin
                wrq.push_back('{bank: b, tag: int'(tag_ctr)});
                wcnt[b]++;
            end else begin
                rdq.push_back('{bank: b, tag: int'(tag_ctr)});
            end
            tag_ctr++;
        end
        if (wseen && in_drain && wrq.size() <= LO) in_drain = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NUM_BANKS; i++) wcnt[i] = 0;
        rst = 1'b1; req_valid = 0; req_write = 0; req_bank = '0; req_tag = '0; bank_busy = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R11-style reset state is covered under R1
        chk(cmd_valid == 1'b0, "R1", int'(cmd_valid), 0);
        chk(req_ready == 1'b1, "R1", int'(req_ready), 1);
        req_write = 1'b1;
        #1;
        chk(req_ready == 1'b1, "R1", int'(req_ready), 1);
        @(negedge clk);

        // directed: banks 0 and 1 busy while requests pile up
        for (int i = 0; i < 3; i++) step(1, 0, 1, 8'b0000_0011);
        step(1, 0, 0, 8'b0000_0011);
        for (int i = 0; i < 6; i++) step(1, 1, 0, 8'b0000_0011);
        for (int i = 0; i < 5; i++) step(0, 0, 0, 8'b0000_0001);
        chk(n_stage == 3, "R7", n_stage, 3);
        chk(n_read == 0, "R5", n_read, 0);
        for (int i = 0; i < 40; i++) step(0, 0, 0, 8'b0000_0000);
        chk(gap_seen == G, "R6", gap_seen, G);
        chk(wrq.size() == LO, "R4", wrq.size(), LO);
        chk(n_read == 1 && rdq.size() == 0, "R7", n_read, 1);
        chk(stq.size() == 0, "R9", stq.size(), 0);

        // directed: fill the write queue while every bank is busy
        for (int i = 0; i < 6; i++) step(1, 1, i % NUM_BANKS, 8'hFF);
        step(1, 1, 3, 8'hFF);
        chk(last_acc == 0, "R1", int'(last_acc), 0);
        for (int i = 0; i < 60; i++) step(0, 0, 0, 8'h00);
        chk(wrq.size() <= LO, "R4", wrq.size(), LO);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [NUM_BANKS-1:0] busy;
            busy = NUM_BANKS'($urandom & $urandom);
            step(bit'($urandom % 2), bit'($urandom % 2), int'($urandom % NUM_BANKS), busy);
        end
        for (int i = 0; i < 200; i++) step(0, 0, 0, 8'h00);
        chk(rdq.size() == 0 && stq.size() == 0, "R10", rdq.size() + stq.size(), 0);
        chk(wrq.size() < HI, "R4", wrq.size(), HI - 1);
        chk(n_stage > 3, "R8", n_stage, 4);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule